// File: doc/BRIEF.md
# Process-Tagged Fully Associative Translation Cache

This block holds recently used address translations. Each entry maps a virtual page number, qualified by a process identifier, to a page frame number and a small set of protection bits. A lookup presents a page number, a process identifier and an untranslated page offset. In the same cycle it returns a hit flag, the frame number, the protection bits and the physical address. The physical address is the frame number with the offset appended below it. Every entry is compared with the key in parallel.

After a miss, the surrounding logic fetches the translation elsewhere and writes it through the fill port. The block chooses the slot itself. It prefers an existing entry with the same key, then the lowest-numbered empty slot, and only then evicts the least recently used entry. Recency is true LRU, and both lookup hits and fills refresh it. Because entries carry the process identifier, a context switch needs no flush. A single entry can still be dropped after its protection changes, and a full flush is available.

Top module: `tlb`

## Requirements
- R1: With `lk_en` high, a lookup whose page number and process identifier both equal those of a valid entry drives `lk_hit` high, with that entry's frame number and protection bits, in the same cycle.
- R2: A lookup whose page number matches a valid entry but whose process identifier differs misses. Two entries with the same page number and different identifiers each return their own frame.
- R3: While empty slots remain, a fill writes into an empty slot and evicts nothing, so every earlier translation still hits.
- R4: A fill whose page number and identifier equal those of a valid entry overwrites that entry with the new frame and bits. No second copy is made and no other entry is evicted.
- R5: A fill into a full block evicts the valid entry that has gone longest without a lookup hit or a fill. Every lookup hit and every fill makes its entry the most recently used.
- R6: An invalidate request (`iv_en`) removes only the valid entry whose page number and identifier equal `iv_vpn`/`iv_pid`. All other entries keep hitting.
- R7: `flush_all` clears every entry at the next clock edge. A lookup in the same cycle as `flush_all` reports a miss.
- R8: Write requests have a fixed priority: flush first, then invalidate, then fill. A fill in the same cycle as `flush_all` or `iv_en` is discarded.
- R9: After reset, and after any later reset pulse, every lookup misses.
- R10: On a hit, `lk_paddr` equals `{lk_pfn, lk_off}`, with the frame number in the upper bits and the offset in the low `OFF_W` bits.
- R11: Invalidating a key that is not present changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_en | input | 1 | Lookup request; a hit refreshes recency |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_pid | input | PID_W | Lookup process identifier |
| lk_off | input | OFF_W | Untranslated page offset |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Frame number of the hit entry |
| lk_perm | output | PERM_W | Protection bits of the hit entry |
| lk_paddr | output | PFN_W+OFF_W | Physical address: frame number above offset |
| fl_en | input | 1 | Fill request |
| fl_vpn | input | VPN_W | Fill page number |
| fl_pid | input | PID_W | Fill process identifier |
| fl_pfn | input | PFN_W | Fill frame number |
| fl_perm | input | PERM_W | Fill protection bits |
| iv_en | input | 1 | Single-entry invalidate request |
| iv_vpn | input | VPN_W | Page number to invalidate |
| iv_pid | input | PID_W | Process identifier to invalidate |
| flush_all | input | 1 | Clear all entries |

## Verification
The bench builds the block with `ENTRIES` set to 4 and keeps the default widths: a 20-bit page number, a 20-bit frame number, an 8-bit process identifier and 4 protection bits. With only four slots, five fills are enough to fill the block and force an eviction. The recency order can then be tracked by hand through a short vector table, so the exact victim is known after hits, overwrites, invalidates and refills into a hole. The full-width identifiers still allow two processes to share one page number.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Write-side action chosen for a cycle, listed by falling priority.
    typedef enum logic [1:0] {
        WR_CLEAR = 2'd0,
        WR_KILL  = 2'd1,
        WR_FILL  = 2'd2,
        WR_IDLE  = 2'd3
    } wr_op_e;

    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PID_W   = 8
) (
    input  logic [ENTRIES-1:0]            valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] tag_vpn,
    input  logic [ENTRIES-1:0][PID_W-1:0] tag_pid,
    input  logic [VPN_W-1:0]              key_vpn,
    input  logic [PID_W-1:0]              key_pid,
    output logic [ENTRIES-1:0]            match
);

    // One comparator per slot, all evaluated at once.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tag_vpn[g] == key_vpn) && (tag_pid[g] == key_pid);
    end

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
    parameter int ENTRIES = 16,
    localparam int IW     = tlb_pkg::idx_bits(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          touch_a,
    input  logic [IW-1:0] idx_a,
    input  logic          touch_b,
    input  logic [IW-1:0] idx_b,
    output logic [IW-1:0] oldest
);

    // rank 0 = most recent, ENTRIES-1 = least recent; ranks form a permutation.
    logic [ENTRIES-1:0][IW-1:0] rank_q, rank_a, rank_b;
    logic [ENTRIES-1:0]         is_old;

    always_comb begin
        rank_a = rank_q;
        if (touch_a) begin
            for (int i = 0; i < ENTRIES; i++)
                if (rank_q[i] < rank_q[idx_a]) rank_a[i] = rank_q[i] + IW'(1);
            rank_a[idx_a] = '0;
        end
        rank_b = rank_a;
        if (touch_b) begin
            for (int i = 0; i < ENTRIES; i++)
                if (rank_a[i] < rank_a[idx_b]) rank_b[i] = rank_a[i] + IW'(1);
            rank_b[idx_b] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IW'(i);
        end else begin
            rank_q <= rank_b;
        end
    end

    always_comb begin
        oldest = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            is_old[i] = (rank_q[i] == IW'(ENTRIES - 1));
            if (is_old[i]) oldest = IW'(i);
        end
    end

    // R5: exactly one slot is ever the eviction candidate.
    p_single_oldest_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot(is_old));

    // R5: a filled slot becomes the most recent one.
    p_fill_is_newest_r5: assert property (@(posedge clk) disable iff (rst)
        touch_b |=> rank_q[$past(idx_b)] == '0);

endmodule

// File: rtl/tlb.sv
module tlb
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int PID_W   = 8,
    parameter int PERM_W  = 4,
    parameter int OFF_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   lk_en,
    input  logic [VPN_W-1:0]       lk_vpn,
    input  logic [PID_W-1:0]       lk_pid,
    input  logic [OFF_W-1:0]       lk_off,
    output logic                   lk_hit,
    output logic [PFN_W-1:0]       lk_pfn,
    output logic [PERM_W-1:0]      lk_perm,
    output logic [PFN_W+OFF_W-1:0] lk_paddr,
    input  logic                   fl_en,
    input  logic [VPN_W-1:0]       fl_vpn,
    input  logic [PID_W-1:0]       fl_pid,
    input  logic [PFN_W-1:0]       fl_pfn,
    input  logic [PERM_W-1:0]      fl_perm,
    input  logic                   iv_en,
    input  logic [VPN_W-1:0]       iv_vpn,
    input  logic [PID_W-1:0]       iv_pid,
    input  logic                   flush_all
);

    localparam int IW = idx_bits(ENTRIES);

    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][PID_W-1:0]  pid_q;
    logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
    logic [ENTRIES-1:0][PERM_W-1:0] perm_q;

    logic [ENTRIES-1:0] lk_match, iv_match, fl_match;
    logic [IW-1:0]      lk_idx, dup_idx, free_idx, victim_idx, fill_idx;
    logic               has_free;
    wr_op_e             op;

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_lk (
        .valid(valid_q), .tag_vpn(vpn_q), .tag_pid(pid_q),
        .key_vpn(lk_vpn), .key_pid(lk_pid), .match(lk_match));

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_iv (
        .valid(valid_q), .tag_vpn(vpn_q), .tag_pid(pid_q),
        .key_vpn(iv_vpn), .key_pid(iv_pid), .match(iv_match));

    tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) u_cam_fl (
        .valid(valid_q), .tag_vpn(vpn_q), .tag_pid(pid_q),
        .key_vpn(fl_vpn), .key_pid(fl_pid), .match(fl_match));

    // Write priority: flush, then invalidate, then fill.
    always_comb begin
        if (flush_all)  op = WR_CLEAR;
        else if (iv_en) op = WR_KILL;
        else if (fl_en) op = WR_FILL;
        else            op = WR_IDLE;
    end

    // Index encoders; the lowest set index wins.
    always_comb begin
        lk_idx   = '0;
        dup_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_match[i]) lk_idx   = IW'(i);
            if (fl_match[i]) dup_idx  = IW'(i);
            if (!valid_q[i]) free_idx = IW'(i);
        end
        has_free = ~&valid_q;
        if (|fl_match)     fill_idx = dup_idx;
        else if (has_free) fill_idx = free_idx;
        else               fill_idx = victim_idx;
    end

    assign lk_hit   = lk_en && (|lk_match) && !flush_all;
    assign lk_pfn   = pfn_q[lk_idx];
    assign lk_perm  = perm_q[lk_idx];
    assign lk_paddr = {lk_pfn, lk_off};

    tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk(clk), .rst(rst),
        .touch_a(lk_hit), .idx_a(lk_idx),
        .touch_b(op == WR_FILL), .idx_b(fill_idx),
        .oldest(victim_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            case (op)
                WR_CLEAR: valid_q <= '0;
                WR_KILL:  valid_q <= valid_q & ~iv_match;
                WR_FILL:  valid_q[fill_idx] <= 1'b1;
                default:  valid_q <= valid_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (op == WR_FILL) begin
            vpn_q[fill_idx]  <= fl_vpn;
            pid_q[fill_idx]  <= fl_pid;
            pfn_q[fill_idx]  <= fl_pfn;
            perm_q[fill_idx] <= fl_perm;
        end
    end

    // R4: no key is ever held twice, so at most one slot matches a lookup.
    p_no_twin_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match));

    // R7: a flush leaves nothing valid.
    p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_q == '0));

    // R6: invalidating a present key removes exactly one entry.
    p_kill_exactly_one_r6: assert property (@(posedge clk) disable iff (rst)
        (op == WR_KILL && |iv_match) |=>
            ($countones(valid_q) + 1 == $past($countones(valid_q))));

    // R11: invalidating an absent key keeps the valid set.
    p_kill_absent_r11: assert property (@(posedge clk) disable iff (rst)
        (op == WR_KILL && !(|iv_match)) |=> $stable(valid_q));

endmodule

// File: tb/test_tlb.sv
module test_tlb;

    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        lk_en, lk_hit;
    logic [19:0] lk_vpn, lk_pfn;
    logic [7:0]  lk_pid;
    logic [11:0] lk_off;
    logic [3:0]  lk_perm;
    logic [31:0] lk_paddr;
    logic        fl_en;
    logic [19:0] fl_vpn, fl_pfn;
    logic [7:0]  fl_pid;
    logic [3:0]  fl_perm;
    logic        iv_en;
    logic [19:0] iv_vpn;
    logic [7:0]  iv_pid;
    logic        flush_all;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tlb #(.ENTRIES(N)) i_tlb (
        .clk(clk), .rst(rst),
        .lk_en(lk_en), .lk_vpn(lk_vpn), .lk_pid(lk_pid), .lk_off(lk_off),
        .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm), .lk_paddr(lk_paddr),
        .fl_en(fl_en), .fl_vpn(fl_vpn), .fl_pid(fl_pid), .fl_pfn(fl_pfn), .fl_perm(fl_perm),
        .iv_en(iv_en), .iv_vpn(iv_vpn), .iv_pid(iv_pid),
        .flush_all(flush_all));

    // kind: 0 lookup, 1 fill, 2 invalidate
    typedef struct packed {
        logic [1:0]  kind;
        logic [19:0] vpn;
        logic [7:0]  pid;
        logic [19:0] pfn;
        logic [3:0]  perm;
        logic        hit;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [0:26] = '{
        '{2'd0, 20'h00100, 8'h11, 20'h00000, 4'h0, 1'b0, 4'd9},  // R9 empty after reset
        '{2'd1, 20'h00100, 8'h11, 20'hA0100, 4'h5, 1'b0, 4'd3},  // R3 fill slot0
        '{2'd1, 20'h00101, 8'h11, 20'hA0101, 4'h3, 1'b0, 4'd3},
        '{2'd1, 20'h00102, 8'h11, 20'hA0102, 4'h1, 1'b0, 4'd3},
        '{2'd1, 20'h00100, 8'h22, 20'hB0100, 4'h2, 1'b0, 4'd2},  // R2 same page, other pid
        '{2'd0, 20'h00100, 8'h11, 20'hA0100, 4'h5, 1'b1, 4'd1},  // R1, R10
        '{2'd0, 20'h00100, 8'h22, 20'hB0100, 4'h2, 1'b1, 4'd2},  // R2
        '{2'd0, 20'h00100, 8'h33, 20'h00000, 4'h0, 1'b0, 4'd2},  // R2 unknown pid
        '{2'd0, 20'h00101, 8'h11, 20'hA0101, 4'h3, 1'b1, 4'd3},  // R3 nothing evicted
        '{2'd0, 20'h00102, 8'h11, 20'hA0102, 4'h1, 1'b1, 4'd3},
        '{2'd0, 20'h00100, 8'h11, 20'hA0100, 4'h5, 1'b1, 4'd5},  // R5 refresh; oldest is 100/22
        '{2'd1, 20'h00103, 8'h11, 20'hA0103, 4'h6, 1'b0, 4'd5},  // R5 evicts 100/22
        '{2'd0, 20'h00100, 8'h22, 20'h00000, 4'h0, 1'b0, 4'd5},
        '{2'd0, 20'h00100, 8'h11, 20'hA0100, 4'h5, 1'b1, 4'd5},
        '{2'd1, 20'h00101, 8'h11, 20'hC0101, 4'h7, 1'b0, 4'd4},  // R4 overwrite in place
        '{2'd0, 20'h00101, 8'h11, 20'hC0101, 4'h7, 1'b1, 4'd4},
        '{2'd0, 20'h00102, 8'h11, 20'hA0102, 4'h1, 1'b1, 4'd4},  // R4 no eviction
        '{2'd0, 20'h00103, 8'h11, 20'hA0103, 4'h6, 1'b1, 4'd4},
        '{2'd2, 20'h00102, 8'h11, 20'h00000, 4'h0, 1'b0, 4'd6},  // R6 drop one
        '{2'd0, 20'h00102, 8'h11, 20'h00000, 4'h0, 1'b0, 4'd6},
        '{2'd0, 20'h00101, 8'h11, 20'hC0101, 4'h7, 1'b1, 4'd6},
        '{2'd2, 20'h00555, 8'h11, 20'h00000, 4'h0, 1'b0, 4'd11}, // R11 absent key
        '{2'd0, 20'h00103, 8'h11, 20'hA0103, 4'h6, 1'b1, 4'd11},
        '{2'd1, 20'h00104, 8'h22, 20'hD0104, 4'h9, 1'b0, 4'd3},  // R3 fills the hole
        '{2'd0, 20'h00100, 8'h11, 20'hA0100, 4'h5, 1'b1, 4'd3},  // oldest survived
        '{2'd0, 20'h00104, 8'h22, 20'hD0104, 4'h9, 1'b1, 4'd3},
        '{2'd0, 20'h00101, 8'h11, 20'hC0101, 4'h7, 1'b1, 4'd3}
    };

    task automatic idle_inputs();
        lk_en = 1'b0; lk_vpn = '0; lk_pid = '0; lk_off = 12'h3C5;
        fl_en = 1'b0; fl_vpn = '0; fl_pid = '0; fl_pfn = '0; fl_perm = '0;
        iv_en = 1'b0; iv_vpn = '0; iv_pid = '0;
        flush_all = 1'b0;
    endtask

    task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Lookup at the current negedge; outputs sampled 1 ns later.
    task automatic look(input int req, input logic [19:0] v, input logic [7:0] p,
                        input bit exp_hit, input logic [19:0] exp_pfn, input logic [3:0] exp_perm);
        lk_en = 1'b1; lk_vpn = v; lk_pid = p;
        #1;
        check(req, "hit", {31'd0, lk_hit}, {31'd0, exp_hit});
        if (exp_hit) begin
            check(req, "pfn", {12'd0, lk_pfn}, {12'd0, exp_pfn});
            check(req, "perm", {28'd0, lk_perm}, {28'd0, exp_perm});
            check(10, "paddr", lk_paddr, {exp_pfn, lk_off}); // R10
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        foreach (VECS[k]) begin
            case (VECS[k].kind)
                2'd0: look(int'(VECS[k].req), VECS[k].vpn, VECS[k].pid, VECS[k].hit, VECS[k].pfn, VECS[k].perm);
                2'd1: begin
                    fl_en = 1'b1; fl_vpn = VECS[k].vpn; fl_pid = VECS[k].pid;
                    fl_pfn = VECS[k].pfn; fl_perm = VECS[k].perm;
                end
                default: begin
                    iv_en = 1'b1; iv_vpn = VECS[k].vpn; iv_pid = VECS[k].pid;
                end
            endcase
            next_cycle();
        end

        // R7: lookup during a flush misses, and everything is gone afterwards.
        flush_all = 1'b1;
        look(7, 20'h00100, 8'h11, 1'b0, '0, '0);
        next_cycle();
        look(7, 20'h00101, 8'h11, 1'b0, '0, '0);
        next_cycle();

        // R8: fill alongside a flush is discarded.
        flush_all = 1'b1;
        fl_en = 1'b1; fl_vpn = 20'h00200; fl_pid = 8'h11; fl_pfn = 20'hE0200; fl_perm = 4'h1;
        next_cycle();
        look(8, 20'h00200, 8'h11, 1'b0, '0, '0);
        next_cycle();

        // R8: fill alongside an invalidate is discarded; the invalidate applies.
        fl_en = 1'b1; fl_vpn = 20'h00201; fl_pid = 8'h11; fl_pfn = 20'hE0201; fl_perm = 4'h2;
        next_cycle();
        look(1, 20'h00201, 8'h11, 1'b1, 20'hE0201, 4'h2); // R1
        next_cycle();
        iv_en = 1'b1; iv_vpn = 20'h00201; iv_pid = 8'h11;
        fl_en = 1'b1; fl_vpn = 20'h00202; fl_pid = 8'h11; fl_pfn = 20'hE0202; fl_perm = 4'h3;
        next_cycle();
        look(8, 20'h00202, 8'h11, 1'b0, '0, '0);
        next_cycle();
        look(8, 20'h00201, 8'h11, 1'b0, '0, '0);
        next_cycle();

        // R9: a reset pulse empties the block.
        fl_en = 1'b1; fl_vpn = 20'h00203; fl_pid = 8'h44; fl_pfn = 20'hE0203; fl_perm = 4'h4;
        next_cycle();
        look(9, 20'h00203, 8'h44, 1'b1, 20'hE0203, 4'h4);
        next_cycle();
        rst = 1'b1;
        next_cycle();
        rst = 1'b0;
        look(9, 20'h00203, 8'h44, 1'b0, '0, '0);
        next_cycle();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule